// File: doc/BRIEF.md
# Dual Stepper Phase Sequencer

This block drives two stepper motors, motor 0 (scanner) and motor 1 (printer). Each motor has four phase lines that go to external current drivers. Each motor walks through its own small pattern table, one entry per step. A step happens once every step interval, and the interval is picked from four line-time multiples of a base period. Firmware starts a move by writing a step count. The motor raises its power-enable at once and changes phase one interval later. When the move ends, an idle timer counts down, and when it expires the power-enable drops and the phase lines go dark.

Either motor can be switched into general-purpose output mode. In that mode its four lines show a value held in a register. Its sequencer, step counter and idle timer are frozen, and its power-enable reads low. When the motor leaves that mode, the sequencer picks up exactly where it stopped. All settings arrive over a simple write-only register port. The address holds a motor-select bit above a 4-bit field code.

Top module: `stepper_phase_seq`

## Requirements
- R1: `motorOut[3:0]` belongs to motor 0 and `motorOut[7:4]` to motor 1. Address bit 4 selects the motor. After reset all eight outputs, both power-enables and both busy flags are 0.
- R2: Field codes 0 to 7 write pattern entries 0 to 7 (data bits 3:0). While a motor is powered in stepper mode, its four lines equal the entry at its current index. The index is 0 after reset.
- R3: The settings field (code 8) holds the sequence length minus one in bits 2:0. With bit 3 = 0, each step increments the index, and the index wraps from length-1 back to 0.
- R4: With settings bit 3 = 1, each step decrements the index, and the index wraps from 0 to length-1.
- R5: Settings bits 5:4 select the step interval as LINE_BASE shifted left by that value (in clock cycles). The first phase change comes one full interval after the start write.
- R6: A nonzero write to the count field (code 11) makes the motor issue exactly that many steps. Busy stays high from the write until the last step.
- R7: A start write raises power-enable in the cycle after the write, one interval before the first phase change. A count write of zero has no effect.
- R8: The timeout field (code 9) sets the idle period T. Power-enable drops T+1 cycles after the last step. While power is off in stepper mode, the lines read 0.
- R9: A new start write while the motor is idle and still powered reloads the idle period, so power stays on.
- R10: Settings bit 6 selects output mode. In that mode the lines show field code 10 (bits 3:0) and power-enable reads 0. Index, remaining count and interval timing are frozen, and start writes are ignored. Leaving the mode resumes the run where it stopped.
- R11: Writes to one motor leave the other motor's table, settings, index and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Bit 4 motor select, bits 3:0 field code |
| wrData | input | 16 | Write data |
| motorOut | output | 8 | Phase lines, motor 1 in the upper nibble |
| powerEn | output | 2 | Per-motor driver power enable |
| busy | output | 2 | Per-motor steps outstanding |

## Verification
The hardest case to reach is a freeze in the middle of a run. Output mode must be entered while steps are still outstanding and the interval timer is part way through its count. A start write must then arrive while the mode is active and be discarded. The stimulus starts an eight-step run on motor 1 and switches on output mode two cycles after a phase change. It issues a one-step request during the freeze and then returns to stepper mode. The expected values count the remaining interval cycles and the six remaining steps. A wrong freeze or an accepted request shifts every later phase change or its total.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
  localparam int FIELD_W = 4;
  localparam int SEL_W   = 2;

  localparam logic [FIELD_W-1:0] FLD_SETTINGS = 4'd8;
  localparam logic [FIELD_W-1:0] FLD_TIMEOUT  = 4'd9;
  localparam logic [FIELD_W-1:0] FLD_GPOVAL   = 4'd10;
  localparam logic [FIELD_W-1:0] FLD_COUNT    = 4'd11;

  // strobes the control side issues to the datapath, one set per motor
  typedef struct packed {
    logic advance;
    logic pwrSet;
    logic pwrClr;
  } motor_strobe_t;
endpackage

// File: rtl/stepseq_datapath.sv
module stepseq_datapath
  import stepseq_pkg::*;
#(
  parameter int NUM_MOTORS = 2,
  parameter int PHASES     = 4,
  parameter int DEPTH      = 8,
  parameter int DATA_W     = 16
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 wrEn,
  input  logic [((NUM_MOTORS > 1) ? $clog2(NUM_MOTORS) : 1)+FIELD_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]                    wrData,
  input  motor_strobe_t [NUM_MOTORS-1:0]       strobe,
  output logic [NUM_MOTORS-1:0]                gpoMode,
  output logic [NUM_MOTORS-1:0][SEL_W-1:0]     intervalSel,
  output logic [NUM_MOTORS-1:0][DATA_W-1:0]    timeoutVal,
  output logic [NUM_MOTORS-1:0]                pwrOn,
  output logic [NUM_MOTORS*PHASES-1:0]         motorOut,
  output logic [NUM_MOTORS-1:0]                powerEn
);
  localparam int MSEL_W = (NUM_MOTORS > 1) ? $clog2(NUM_MOTORS) : 1;
  localparam int ADDR_W = MSEL_W + FIELD_W;
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [FIELD_W-1:0] field;
  assign field = wrAddr[FIELD_W-1:0];

  for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_motor
    logic [PHASES-1:0] patTable [DEPTH];
    logic [IDX_W-1:0]  lenM1, idx, nextIdx;
    logic              revDir, gpo, pwr, wrHit;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] tmo;
    logic [PHASES-1:0] gpoVal;

    assign wrHit = wrEn && (wrAddr[ADDR_W-1:FIELD_W] == MSEL_W'(m));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int e = 0; e < DEPTH; e++) patTable[e] <= '0;
        lenM1  <= '0;
        revDir <= 1'b0;
        sel    <= '0;
        gpo    <= 1'b0;
        tmo    <= '0;
        gpoVal <= '0;
      end else if (wrHit) begin
        if (field < FIELD_W'(DEPTH)) begin
          patTable[field[IDX_W-1:0]] <= wrData[PHASES-1:0];
        end else if (field == FLD_SETTINGS) begin
          lenM1  <= wrData[IDX_W-1:0];
          revDir <= wrData[IDX_W];
          sel    <= wrData[IDX_W+SEL_W:IDX_W+1];
          gpo    <= wrData[IDX_W+SEL_W+1];
        end else if (field == FLD_TIMEOUT) begin
          tmo <= wrData;
        end else if (field == FLD_GPOVAL) begin
          gpoVal <= wrData[PHASES-1:0];
        end
      end
    end

    // index successor with wrap in both directions
    always_comb begin
      if (revDir) begin
        nextIdx = (idx == '0 || idx > lenM1) ? lenM1 : idx - 1'b1;
      end else begin
        nextIdx = (idx >= lenM1) ? '0 : idx + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        idx <= '0;
        pwr <= 1'b0;
      end else begin
        if (strobe[m].advance) idx <= nextIdx;
        if (strobe[m].pwrSet)      pwr <= 1'b1;
        else if (strobe[m].pwrClr) pwr <= 1'b0;
      end
    end

    assign gpoMode[m]     = gpo;
    assign intervalSel[m] = sel;
    assign timeoutVal[m]  = tmo;
    assign pwrOn[m]       = pwr;
    assign powerEn[m]     = pwr && !gpo;
    assign motorOut[m*PHASES +: PHASES] =
      gpo ? gpoVal : (pwr ? patTable[idx] : '0);
  end
endmodule

// File: rtl/stepseq_ctrl.sv
module stepseq_ctrl
  import stepseq_pkg::*;
#(
  parameter int NUM_MOTORS = 2,
  parameter int DATA_W     = 16,
  parameter int LINE_BASE  = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic [((NUM_MOTORS > 1) ? $clog2(NUM_MOTORS) : 1)+FIELD_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic [NUM_MOTORS-1:0]             gpoMode,
  input  logic [NUM_MOTORS-1:0][SEL_W-1:0]  intervalSel,
  input  logic [NUM_MOTORS-1:0][DATA_W-1:0] timeoutVal,
  input  logic [NUM_MOTORS-1:0]             pwrOn,
  output motor_strobe_t [NUM_MOTORS-1:0]    strobe,
  output logic [NUM_MOTORS-1:0]             busy
);
  localparam int MSEL_W       = (NUM_MOTORS > 1) ? $clog2(NUM_MOTORS) : 1;
  localparam int ADDR_W       = MSEL_W + FIELD_W;
  localparam int MAX_INTERVAL = LINE_BASE << ((1 << SEL_W) - 1);
  localparam int TICK_W       = (MAX_INTERVAL > 1) ? $clog2(MAX_INTERVAL) : 1;

  for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_motor
    logic [TICK_W-1:0] tickCnt, reloadVal;
    logic [DATA_W-1:0] remaining, idleCnt;
    logic              loadHit, running, stepNow, idleOut;

    assign loadHit = wrEn && (wrAddr[ADDR_W-1:FIELD_W] == MSEL_W'(m)) &&
                     (wrAddr[FIELD_W-1:0] == FLD_COUNT) && !gpoMode[m] &&
                     (wrData != '0);
    assign reloadVal = TICK_W'((LINE_BASE << intervalSel[m]) - 1);
    assign running   = !gpoMode[m] && !loadHit;
    assign stepNow   = running && (remaining != '0) && (tickCnt == '0);
    assign idleOut   = running && (remaining == '0) && pwrOn[m] && (idleCnt == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tickCnt   <= '0;
        remaining <= '0;
        idleCnt   <= '0;
      end else if (loadHit) begin
        remaining <= wrData;
        tickCnt   <= reloadVal;
        idleCnt   <= timeoutVal[m];
      end else if (running) begin
        if (remaining != '0) begin
          if (tickCnt == '0) begin
            tickCnt   <= reloadVal;
            remaining <= remaining - 1'b1;
            idleCnt   <= timeoutVal[m];
          end else begin
            tickCnt <= tickCnt - 1'b1;
          end
        end else if (pwrOn[m] && idleCnt != '0) begin
          idleCnt <= idleCnt - 1'b1;
        end
      end
    end

    assign strobe[m] = '{advance: stepNow, pwrSet: loadHit, pwrClr: idleOut};
    assign busy[m]   = (remaining != '0);
  end
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepseq_pkg::*;
#(
  parameter int NUM_MOTORS = 2,
  parameter int PHASES     = 4,
  parameter int DEPTH      = 8,
  parameter int DATA_W     = 16,
  parameter int LINE_BASE  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [4:0]                   wrAddr,
  input  logic [DATA_W-1:0]            wrData,
  output logic [NUM_MOTORS*PHASES-1:0] motorOut,
  output logic [NUM_MOTORS-1:0]        powerEn,
  output logic [NUM_MOTORS-1:0]        busy
);
  motor_strobe_t [NUM_MOTORS-1:0]    strobe;
  logic [NUM_MOTORS-1:0]             gpoMode;
  logic [NUM_MOTORS-1:0][SEL_W-1:0]  intervalSel;
  logic [NUM_MOTORS-1:0][DATA_W-1:0] timeoutVal;
  logic [NUM_MOTORS-1:0]             pwrOn;

  stepseq_datapath #(
    .NUM_MOTORS(NUM_MOTORS), .PHASES(PHASES), .DEPTH(DEPTH), .DATA_W(DATA_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .gpoMode(gpoMode), .intervalSel(intervalSel),
    .timeoutVal(timeoutVal), .pwrOn(pwrOn), .motorOut(motorOut),
    .powerEn(powerEn)
  );

  stepseq_ctrl #(
    .NUM_MOTORS(NUM_MOTORS), .DATA_W(DATA_W), .LINE_BASE(LINE_BASE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .gpoMode(gpoMode), .intervalSel(intervalSel), .timeoutVal(timeoutVal),
    .pwrOn(pwrOn), .strobe(strobe), .busy(busy)
  );
endmodule

// File: rtl/stepseq_checker.sv
module stepseq_checker
  import stepseq_pkg::*;
#(
  parameter int NUM_MOTORS = 2,
  parameter int PHASES     = 4
) (
  input logic                           clk,
  input logic                           rstN,
  input logic [NUM_MOTORS*PHASES-1:0]   motorOut,
  input logic [NUM_MOTORS-1:0]          powerEn,
  input logic [NUM_MOTORS-1:0]          busy,
  input logic [NUM_MOTORS-1:0]          gpoMode,
  input motor_strobe_t [NUM_MOTORS-1:0] strobe
);
  for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_chk
    AST_BUSY_POWERED: assert property (@(posedge clk) disable iff (!rstN)
      busy[m] && !gpoMode[m] |-> powerEn[m]);                                // R6
    AST_DARK_UNPOWERED: assert property (@(posedge clk) disable iff (!rstN)
      !powerEn[m] && !gpoMode[m] |-> motorOut[m*PHASES +: PHASES] == '0);     // R8
    AST_TIMEOUT_OFF: assert property (@(posedge clk) disable iff (!rstN)
      strobe[m].pwrClr |=> !powerEn[m]);                                     // R8
    AST_GPO_UNPOWERED: assert property (@(posedge clk) disable iff (!rstN)
      gpoMode[m] |-> !powerEn[m]);                                           // R10
    AST_GPO_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
      $past(gpoMode[m]) |-> $stable(busy[m]));                               // R10
    AST_STEP_POWERED: assert property (@(posedge clk) disable iff (!rstN)
      strobe[m].advance |-> powerEn[m]);                                     // R7
    AST_POWER_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(powerEn[m]) |-> ($past(strobe[m].pwrSet) || $fell(gpoMode[m]))); // R7
  end
endmodule

bind stepper_phase_seq stepseq_checker #(
  .NUM_MOTORS(NUM_MOTORS), .PHASES(PHASES)
) i_checker (
  .clk(clk), .rstN(rstN), .motorOut(motorOut), .powerEn(powerEn),
  .busy(busy), .gpoMode(gpoMode), .strobe(strobe)
);

// File: tb/test_stepper_phase_seq.sv
module test_stepper_phase_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [7:0] motorOut;
  logic [1:0] powerEn;
  logic [1:0] busy;

  stepper_phase_seq i_stepper_phase_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .motorOut(motorOut), .powerEn(powerEn), .busy(busy)
  );

  always #5 clk = ~clk;

  typedef struct {
    int         cyc;
    logic [7:0] out;
    logic [1:0] pwr;
    logic [1:0] bsy;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t item;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expectations whose cycle has arrived
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item = q.pop_front();
      checks++;
      if (item.cyc != cyc || motorOut !== item.out || powerEn !== item.pwr ||
          busy !== item.bsy) begin
        fails++;
        $display("FAIL %s at cycle %0d (due %0d): out=%h pwr=%b busy=%b expected out=%h pwr=%b busy=%b",
                 item.tag, cyc, item.cyc, motorOut, powerEn, busy,
                 item.out, item.pwr, item.bsy);
      end
    end
  end

  task automatic expectAt(input int c, input logic [7:0] o, input logic [1:0] p,
                          input logic [1:0] b, input string tag);
    exp_t e;
    e.cyc = c; e.out = o; e.pwr = p; e.bsy = b; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input int mot, input int fld, input int val, output int e);
    wrEn   = 1'b1;
    wrAddr = {mot[0], fld[3:0]};
    wrData = val[15:0];
    @(posedge clk);
    #1;
    e    = cyc;
    wrEn = 1'b0;
  endtask

  task automatic waitCyc(input int c);
    while (cyc < c) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    int e, s, e2, e3, g, x, e4, d;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    expectAt(cyc + 1, 8'h00, 2'b00, 2'b00, "R1 reset state");
    drain();

    // motor 0 table and settings: len 4, forward, sel 0, timeout 5
    wr(0, 0, 4'h1, d); wr(0, 1, 4'h2, d); wr(0, 2, 4'h4, d); wr(0, 3, 4'h8, d);
    wr(0, 4, 4'h3, d); wr(0, 5, 4'h6, d); wr(0, 6, 4'hC, d); wr(0, 7, 4'h9, d);
    wr(0, 8, 16'h0003, d);
    wr(0, 9, 5, s);
    expectAt(s + 1, 8'h00, 2'b00, 2'b00, "R8 dark before any start");
    drain();

    wr(0, 11, 6, e);
    expectAt(e,      8'h01, 2'b01, 2'b01, "R7 power up with index 0 (R2)");
    expectAt(e + 3,  8'h01, 2'b01, 2'b01, "R5 no change before interval");
    expectAt(e + 4,  8'h02, 2'b01, 2'b01, "R5 first step after interval");
    expectAt(e + 8,  8'h04, 2'b01, 2'b01, "R2 table entry 2");
    expectAt(e + 12, 8'h08, 2'b01, 2'b01, "R3 entry at len-1");
    expectAt(e + 16, 8'h01, 2'b01, 2'b01, "R3 forward wrap to 0");
    expectAt(e + 20, 8'h02, 2'b01, 2'b01, "R3 after wrap");
    expectAt(e + 23, 8'h02, 2'b01, 2'b01, "R6 busy before last step");
    expectAt(e + 24, 8'h04, 2'b01, 2'b00, "R6 busy clears after six steps");
    expectAt(e + 29, 8'h04, 2'b01, 2'b00, "R8 power held during timeout");
    expectAt(e + 30, 8'h00, 2'b00, 2'b00, "R8 power off after timeout");
    expectAt(e + 40, 8'h00, 2'b00, 2'b00, "R6 no extra steps");
    drain();

    // reverse, len 8, sel 1 (interval 8); index is 2
    wr(0, 8, 16'h001F, d);
    wr(0, 11, 4, e);
    expectAt(e,      8'h04, 2'b01, 2'b01, "R4 start at index 2");
    expectAt(e + 7,  8'h04, 2'b01, 2'b01, "R5 slower interval hold");
    expectAt(e + 8,  8'h02, 2'b01, 2'b01, "R4 decrement");
    expectAt(e + 16, 8'h01, 2'b01, 2'b01, "R4 index 0");
    expectAt(e + 24, 8'h09, 2'b01, 2'b01, "R4 reverse wrap to len-1");
    expectAt(e + 32, 8'h0C, 2'b01, 2'b00, "R6 four steps done");
    waitCyc(e + 34);
    wr(0, 11, 1, e2);
    expectAt(e2,      8'h0C, 2'b01, 2'b01, "R9 restart while idle");
    expectAt(e + 38,  8'h0C, 2'b01, 2'b01, "R9 timeout reloaded");
    expectAt(e2 + 7,  8'h0C, 2'b01, 2'b01, "R9 hold");
    expectAt(e2 + 8,  8'h06, 2'b00 | 2'b01, 2'b00, "R9 single step");
    expectAt(e2 + 13, 8'h06, 2'b01, 2'b00, "R8 still powered");
    expectAt(e2 + 14, 8'h00, 2'b00, 2'b00, "R8 off");
    drain();

    // zero count has no effect
    wr(0, 11, 0, e);
    expectAt(e,     8'h00, 2'b00, 2'b00, "R7 zero count ignored");
    expectAt(e + 6, 8'h00, 2'b00, 2'b00, "R7 zero count stays idle");
    drain();

    // motor 1: len 4 forward sel 0, timeout 2, output value 0xA
    wr(1, 0, 4'h3, d); wr(1, 1, 4'h6, d); wr(1, 2, 4'hC, d); wr(1, 3, 4'h9, d);
    wr(1, 8, 16'h0003, d); wr(1, 9, 2, d); wr(1, 10, 4'hA, d);
    wr(1, 11, 8, e3);
    expectAt(e3,     8'h30, 2'b10, 2'b10, "R11 motor 1 starts, motor 0 untouched");
    expectAt(e3 + 4, 8'h60, 2'b10, 2'b10, "R2 motor 1 step");
    expectAt(e3 + 8, 8'hC0, 2'b10, 2'b10, "R2 motor 1 step");
    waitCyc(e3 + 9);
    wr(1, 8, 16'h0043, g);
    expectAt(g, 8'hA0, 2'b00, 2'b10, "R10 output mode value, power low");
    waitCyc(g + 2);
    wr(1, 11, 1, d);
    expectAt(g + 5, 8'hA0, 2'b00, 2'b10, "R10 start ignored in output mode");
    waitCyc(g + 8);
    wr(1, 8, 16'h0003, x);
    expectAt(x,      8'hC0, 2'b10, 2'b10, "R10 resume where stopped");
    expectAt(x + 1,  8'hC0, 2'b10, 2'b10, "R10 interval remainder");
    expectAt(x + 2,  8'h90, 2'b10, 2'b10, "R10 frozen tick resumes");
    expectAt(x + 6,  8'h30, 2'b10, 2'b10, "R3 motor 1 wrap");
    expectAt(x + 10, 8'h60, 2'b10, 2'b10, "R10 run continues");
    expectAt(x + 14, 8'hC0, 2'b10, 2'b10, "R10 run continues");
    expectAt(x + 18, 8'h90, 2'b10, 2'b10, "R10 run continues");
    expectAt(x + 21, 8'h90, 2'b10, 2'b10, "R10 count kept through freeze");
    expectAt(x + 22, 8'h30, 2'b10, 2'b00, "R6 eight steps total");
    expectAt(x + 24, 8'h30, 2'b10, 2'b00, "R8 motor 1 timeout hold");
    expectAt(x + 25, 8'h00, 2'b00, 2'b00, "R8 motor 1 off");
    drain();

    // motor 0 keeps its own settings and index (5)
    wr(0, 11, 1, e4);
    expectAt(e4,      8'h06, 2'b01, 2'b01, "R11 motor 0 index kept");
    expectAt(e4 + 7,  8'h06, 2'b01, 2'b01, "R11 motor 0 interval kept");
    expectAt(e4 + 8,  8'h03, 2'b01, 2'b00, "R11 motor 0 direction kept");
    expectAt(e4 + 14, 8'h00, 2'b00, 2'b00, "R11 motor 0 timeout kept");
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL all: watchdog, actual cycle %0d expected completion earlier", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule